// File: doc/BRIEF.md
# Shift and Rotate Unit

This block shifts or rotates a data operand by an amount taken from a second operand. It supports four operations: logical left, logical right, arithmetic right, and rotate right. Each operation works on either a full 64-bit word or a 32-bit word held in the low half of the operand. Any legal count is applied in a single pass through a logarithmic network of stages. The result is registered, so it appears one clock after the request, together with an output strobe.

In 32-bit mode, the sign bit used by the arithmetic shift and the wrap point of the rotate both move to bit 31. The count is reduced modulo the active width. The upper half of the result is forced to zero.

The block produces no condition flags. It has no carry-in shifts and no multi-cycle operation.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `out_valid` is 0 and `result` is 0.
- R2: With `op_sel` = 0 (logical left), the result is the operand shifted toward bit 63 (bit 31 in 32-bit mode). Vacated low bits are 0 and bits pushed past the top are discarded.
- R3: With `op_sel` = 1 (logical right), the vacated high bits are filled with 0. In 32-bit mode, the zeros enter at bit 31.
- R4: With `op_sel` = 2 (arithmetic right), the vacated high bits take copies of the sign bit. The sign bit is bit 63, or bit 31 in 32-bit mode. For example, -8 shifted by 1 gives -4, with every upper bit still 1.
- R5: With `op_sel` = 3 (rotate right), bits leaving bit 0 re-enter at bit 63. In 32-bit mode they re-enter at bit 31, and only bits 0 to 31 take part.
- R6: When `narrow` = 1 (32-bit mode), result bits 63 to 32 are 0.
- R7: The count is `operand_b` modulo 64 in 64-bit mode and modulo 32 in 32-bit mode. Higher bits of `operand_b` are ignored.
- R8: An effective count of 0 returns the operand unchanged for every operation. In 32-bit mode, this means the low 32 bits of the operand with the upper half zero.
- R9: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. `result` changes only after a cycle with `in_valid` = 1, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| narrow | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| operand_a | input | 64 | Data to shift or rotate |
| operand_b | input | 64 | Count operand (low bits used) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered shifted or rotated value |

## Verification
The assertions check several properties on every accepted request:
- the one-cycle strobe relation, and that the result holds between requests;
- a zero upper half in 32-bit mode;
- pass-through for a zero effective count;
- the fill bit at the vacated edge for the logical and arithmetic shifts.

The exact bit values of the shifted and rotated results can only be shown by the bench. It uses hand-worked vectors, including the -8 arithmetic case, counts that wrap past the active width, and rotations by width minus one. It also sweeps every count for each operation and mode against an independent model.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        OP_SHL  = 2'd0,
        OP_SHR  = 2'd1,
        OP_SAR  = 2'd2,
        OP_ROTR = 2'd3
    } shift_op_e;

endpackage

// File: rtl/shf_amount.sv
module shf_amount #(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] cnt_raw,
    input  logic              narrow,
    output logic [CNT_W-1:0]  amt
);

    // Modulo reduction: keep log2(width) bits, drop the top one in narrow mode.
    always_comb begin
        if (narrow) begin
            amt = {1'b0, cnt_raw[CNT_W-2:0]};
        end else begin
            amt = cnt_raw[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/shf_log_core.sv
module shf_log_core #(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  amt,
    input  logic              rot,
    input  logic              fill,
    output logic [DATA_W-1:0] dst
);

    logic [DATA_W-1:0] lvl [0:CNT_W];

    assign lvl[0] = src;

    // One stage per count bit; stage k moves by 2**k toward bit 0.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [S-1:0] top_in;
        assign top_in     = rot ? lvl[k][S-1:0] : {S{fill}};
        assign lvl[k+1]   = amt[k] ? {top_in, lvl[k][DATA_W-1:S]} : lvl[k];
    end

    assign dst = lvl[CNT_W];

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic              narrow,
    input  logic [DATA_W-1:0] operand_a,
    input  logic [DATA_W-1:0] operand_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    shift_op_e         op;
    logic [CNT_W-1:0]  amt;
    logic [DATA_W-1:0] low_zx;
    logic [DATA_W-1:0] core_src;
    logic [DATA_W-1:0] core_dst;
    logic              core_rot;
    logic              core_fill;
    logic [DATA_W-1:0] next_res;
    logic              valid_q;
    logic [DATA_W-1:0] res_q;

    assign op     = shift_op_e'(op_sel);
    assign low_zx = {{HALF_W{1'b0}}, operand_a[HALF_W-1:0]};

    shf_amount #(.DATA_W(DATA_W)) u_amount (
        .cnt_raw (operand_b),
        .narrow  (narrow),
        .amt     (amt)
    );

    // Operand preparation: every operation is mapped onto one rightward core.
    always_comb begin
        core_rot  = 1'b0;
        core_fill = 1'b0;
        unique case (op)
            OP_SHL:  core_src = bit_rev(narrow ? low_zx : operand_a);
            OP_SHR:  core_src = narrow ? low_zx : operand_a;
            OP_SAR: begin
                core_src  = narrow ? {{HALF_W{operand_a[HALF_W-1]}}, operand_a[HALF_W-1:0]}
                                   : operand_a;
                core_fill = narrow ? operand_a[HALF_W-1] : operand_a[DATA_W-1];
            end
            OP_ROTR: begin
                core_src = narrow ? {operand_a[HALF_W-1:0], operand_a[HALF_W-1:0]}
                                  : operand_a;
                core_rot = 1'b1;
            end
            default: core_src = operand_a;
        endcase
    end

    shf_log_core #(.DATA_W(DATA_W)) u_core (
        .src  (core_src),
        .amt  (amt),
        .rot  (core_rot),
        .fill (core_fill),
        .dst  (core_dst)
    );

    // Result finishing: undo the reversal for left shifts, clear upper half in narrow mode.
    always_comb begin
        next_res = (op == OP_SHL) ? bit_rev(core_dst) : core_dst;
        if (narrow) begin
            next_res[DATA_W-1:HALF_W] = '0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= next_res;
            end
        end
    end

    // Outputs.
    always_comb begin
        out_valid = valid_q;
        result    = res_q;
    end

endmodule

// File: rtl/shift_rotate_chk.sv
module shift_rotate_chk #(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic              narrow,
    input logic [DATA_W-1:0] operand_a,
    input logic [DATA_W-1:0] operand_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    logic zero_cnt;
    assign zero_cnt = narrow ? (operand_b[CNT_W-2:0] == '0) : (operand_b[CNT_W-1:0] == '0);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow) |=> (result[DATA_W-1:HALF_W] == '0));

    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_cnt) |=>
            (result == ($past(narrow) ? {{HALF_W{1'b0}}, $past(operand_a[HALF_W-1:0])}
                                      : $past(operand_a))));

    a_r2_low_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && !zero_cnt) |=> (result[0] == 1'b0));

    a_r3_top_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1 && !narrow && !zero_cnt) |=> (result[DATA_W-1] == 1'b0));

    a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2 && !narrow) |=> (result[DATA_W-1] == $past(operand_a[DATA_W-1])));

endmodule

bind shift_rotate_unit shift_rotate_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;

    typedef struct packed {
        logic [1:0]  op;
        logic        nar;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 64'h5,                   64'd3,  64'h28,                   4'd2},
        '{2'd1, 1'b0, 64'hF,                   64'd2,  64'h3,                    4'd3},
        '{2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 64'd1,  64'hFFFF_FFFF_FFFF_FFFC,  4'd4},
        '{2'd3, 1'b0, 64'h1,                   64'd1,  64'h8000_0000_0000_0000,  4'd5},
        '{2'd2, 1'b1, 64'h0000_0000_8000_0000, 64'd4,  64'h0000_0000_F800_0000,  4'd4},
        '{2'd3, 1'b1, 64'h1,                   64'd1,  64'h0000_0000_8000_0000,  4'd5},
        '{2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4,  64'h0000_0000_0FFF_FFFF,  4'd3},
        '{2'd0, 1'b1, 64'h0000_0000_8000_0001, 64'd1,  64'h2,                    4'd6},
        '{2'd0, 1'b0, 64'h1,                   64'd65, 64'h2,                    4'd7},
        '{2'd1, 1'b1, 64'h10,                  64'd33, 64'h8,                    4'd7},
        '{2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd0,  64'h0123_4567_89AB_CDEF,  4'd8},
        '{2'd2, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'd64, 64'h0000_0000_8000_0000,  4'd8},
        '{2'd3, 1'b0, 64'h8000_0000_0000_0001, 64'd63, 64'h3,                    4'd5},
        '{2'd2, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd63, 64'h0,                    4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        narrow = 1'b0;
    logic [63:0] operand_a = '0;
    logic [63:0] operand_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shift_rotate_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .narrow    (narrow),
        .operand_a (operand_a),
        .operand_b (operand_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] model(input logic [1:0] op, input logic nar,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [31:0] x;
        int n;
        if (nar) begin
            x = a[31:0];
            n = int'(b[4:0]);
            case (op)
                2'd0: return {32'h0, x << n};
                2'd1: return {32'h0, x >> n};
                2'd2: return {32'h0, 32'($signed(x) >>> n)};
                default: return {32'h0, (x >> n) | (x << (32 - n))};
            endcase
        end else begin
            n = int'(b[5:0]);
            case (op)
                2'd0: return a << n;
                2'd1: return a >> n;
                2'd2: return 64'($signed(a) >>> n);
                default: return (a >> n) | (a << (64 - n));
            endcase
        end
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic nar, input logic [63:0] a,
                          input logic [63:0] b, input logic [63:0] exp, input string req);
        @(negedge clk);
        op_sel = op; narrow = nar; operand_a = a; operand_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 valid", {63'h0, out_valid}, 64'h1);
        check(req, result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset result", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'h0, out_valid}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].nar, VECS[i].a, VECS[i].b, VECS[i].exp,
                   $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R6: narrow mode leaves upper half zero for every operation.
        for (int o = 0; o < 4; o++) begin
            run_op(2'(o), 1'b1, 64'hDEAD_BEEF_F00D_CAFE, 64'd7,
                   model(2'(o), 1'b1, 64'hDEAD_BEEF_F00D_CAFE, 64'd7), "R6 upper");
            check("R6 upper zero", {32'h0, result[63:32]}, 64'h0);
        end

        // R9: result holds while idle, valid drops.
        hold = result;
        @(negedge clk);
        operand_a = 64'h1234; operand_b = 64'd2;
        @(negedge clk);
        check("R9 idle valid", {63'h0, out_valid}, 64'h0);
        check("R9 hold", result, hold);

        // R2 R3 R4 R5 R7: sweep all counts, both modes, against the model.
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                for (int c = 0; c < 64; c++) begin
                    logic [63:0] a_pat;
                    logic [63:0] b_pat;
                    a_pat = (c % 2 == 0) ? 64'hF0E1_D2C3_B4A5_9687 : 64'h1F2E_3D4C_8B7A_6958;
                    b_pat = {52'hABC_DEF0_1234_5, 6'h0, 6'(c)};
                    run_op(2'(o), m[0], a_pat, b_pat, model(2'(o), m[0], a_pat, b_pat),
                           $sformatf("R7 sweep op%0d nar%0d cnt%0d", o, m, c));
                end
            end
        end

        // R1: reset mid-stream clears state.
        @(negedge clk);
        op_sel = 2'd0; operand_a = 64'h1; operand_b = 64'd1; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 mid reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 mid reset result", result, 64'h0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule